// File: doc/BRIEF.md
# Delayed Store Write Buffer

This block holds one store between the execute stage and the data array of a deep load/store pipeline. In this pipeline the data-array slots come before the tag-check stage. A store therefore cannot write the array when it first passes through; an array write is permanent and must wait until the tag check has confirmed a hit. The buffer takes the store's address, doubleword data and byte enables and holds the entry as *pending*. When the tag-check result arrives, a hit turns the entry *confirmed* and a miss throws it away and raises a miss pulse.

A confirmed entry is written into the array in the first cycle the array port is free. A free cycle is one with no external use of the array and no load reading it. The usual case is the array slot of the next store, which does not read the array itself. While an entry is held, every load is compared against it. A load to the same doubleword whose bytes are all held in the entry gets the buffered data. A load that needs only some of its bytes from the entry stalls until the entry has drained. One operation arrives from the execute stage per cycle. If a store and a load are presented together, the store wins and the load is ignored.

Top module: `store_delay_buf`

## Requirements
- R1: After reset the buffer is empty: `arr_we`, `fwd_valid`, `stall` and `st_miss` are all 0.
- R2: A store accepted into an empty buffer (`st_req`=1, `stall`=0) is not written to the array in its own cycle, nor in any later cycle before a tag-check hit is reported for it.
- R3: A tag-check hit (`tc_valid`=1, `tc_hit`=1) for a pending entry confirms it. The array write (`arr_we`=1 with the stored `arr_addr`, `arr_wdata`, `arr_be`) happens no earlier than the next cycle, in the first cycle where `arr_busy`=0 and no unstalled load is present. After that write the buffer is empty.
- R4: A tag-check miss (`tc_valid`=1, `tc_hit`=0) for a pending entry sets `st_miss`=1 in that same cycle. The entry is dropped, is never written, and is no longer forwarded.
- R5: A load (`ld_req`=1, `st_req`=0) with the same `ld_addr` as a pending or confirmed entry, a nonzero `ld_be`, and `ld_be & ~entry_be` = 0 gets `fwd_valid`=1 and `fwd_data` = the buffered data in that same cycle, with `stall`=0. Otherwise `fwd_data` is 0.
- R6: A load to the same address whose bytes overlap the entry's (`ld_be & entry_be` ≠ 0) without all being covered gets `stall`=1 and `fwd_valid`=0. If the entry is confirmed and `arr_busy`=0, the entry drains in that same cycle.
- R7: A load with a different address, or with bytes disjoint from the entry's, gets `fwd_valid`=0 and `stall`=0.
- R8: A store arriving while a confirmed entry is held and `arr_busy`=0 is not stalled. The old entry is written in that same cycle and the new store becomes the pending entry.
- R9: A store arriving while the entry is pending, or is confirmed with `arr_busy`=1, gets `stall`=1 and is not accepted. The held entry stays unchanged.
- R10: A tag-check result while no entry is pending has no effect: no miss pulse and no array write.
- R11: While a load is using the array (an unstalled load), a confirmed entry is not written. It is written in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req | input | 1 | Store presented by the execute stage |
| st_addr | input | ADDR_W | Doubleword address of the store |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| ld_req | input | 1 | Load presented by the execute stage |
| ld_addr | input | ADDR_W | Doubleword address of the load |
| ld_be | input | DATA_W/8 | Bytes the load needs |
| tc_valid | input | 1 | Tag-check result is present for the pending store |
| tc_hit | input | 1 | Tag-check result: 1 = hit, 0 = miss |
| arr_busy | input | 1 | Array port taken by another user this cycle |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| arr_be | output | DATA_W/8 | Array write byte enables |
| fwd_valid | output | 1 | Load is served from the buffer |
| fwd_data | output | DATA_W | Forwarded load data |
| stall | output | 1 | Hold the execute stage this cycle |
| st_miss | output | 1 | Pending store missed at tag check |

## Verification
A wrong buffer state always shows up at the ports within a cycle or two. A confirmed entry that was lost never produces its `arr_we` write. A stale entry keeps forwarding to loads that follow it or stalls them with no reason. A write that bypasses the tag check shows `arr_we` during the pending phase or after a miss. The bench sweeps every load byte-enable pattern against a held entry, with the expected forward/stall class computed from the masks. It also walks each order of store, tag result, load and busy cycle, checking the write strobe and payload in the exact cycle they are due.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    typedef enum logic [1:0] {
        SB_EMPTY = 2'd0,
        SB_PEND  = 2'd1,
        SB_CONF  = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sdb_match.sv
module sdb_match #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 8
) (
    input  logic              buf_valid,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [BE_W-1:0]   buf_be,
    input  logic              ld_act,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BE_W-1:0]   ld_be,
    output logic              full_hit,
    output logic              partial
);
    logic            same_dw;
    logic [BE_W-1:0] overlap;
    logic [BE_W-1:0] uncovered;

    always_comb begin
        same_dw   = ld_act && buf_valid && (ld_addr == buf_addr);
        overlap   = ld_be & buf_be;
        uncovered = ld_be & ~buf_be;
        full_hit  = same_dw && (ld_be != '0) && (uncovered == '0);
        partial   = same_dw && (overlap != '0) && (uncovered != '0);
    end
endmodule

// File: rtl/sdb_entry.sv
module sdb_entry
    import sdb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic              ld_act,
    input  logic              ld_partial,
    input  logic              tc_valid,
    input  logic              tc_hit,
    input  logic              arr_busy,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_data,
    output logic [BE_W-1:0]   buf_be,
    output logic              arr_we,
    output logic              st_stall,
    output logic              tc_miss
);
    typedef struct packed {
        sb_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } entry_t;

    entry_t ent_d, ent_q;
    logic   pend, conf, st_take;

    always_comb begin
        ent_d    = ent_q;
        pend     = (ent_q.state == SB_PEND);
        conf     = (ent_q.state == SB_CONF);
        st_stall = st_req && (pend || (conf && arr_busy));
        st_take  = st_req && !st_stall;
        arr_we   = conf && !arr_busy && !(ld_act && !ld_partial);
        tc_miss  = pend && tc_valid && !tc_hit;

        if (pend && tc_valid) begin
            ent_d.state = tc_hit ? SB_CONF : SB_EMPTY;
        end
        if (arr_we) begin
            ent_d.state = SB_EMPTY;
        end
        if (st_take) begin
            ent_d.state = SB_PEND;
            ent_d.addr  = st_addr;
            ent_d.data  = st_data;
            ent_d.be    = st_be;
        end

        buf_valid = pend || conf;
        buf_addr  = ent_q.addr;
        buf_data  = ent_q.data;
        buf_be    = ent_q.be;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '{state: SB_EMPTY, addr: '0, data: '0, be: '0};
        end else begin
            ent_q <= ent_d;
        end
    end

    AST_ACCEPT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_stall) |=> (ent_q.state == SB_PEND)); // R2
    AST_HIT_CONFIRMS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && tc_valid && tc_hit) |=> (ent_q.state == SB_CONF)); // R3
    AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_miss |=> (ent_q.state == SB_EMPTY)); // R4
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_stall && !tc_valid) |=> ($stable(ent_q.addr) && $stable(ent_q.state))); // R9
endmodule

// File: rtl/store_delay_buf.sv
module store_delay_buf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BE_W-1:0]   ld_be,
    input  logic              tc_valid,
    input  logic              tc_hit,
    input  logic              arr_busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [BE_W-1:0]   arr_be,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              stall,
    output logic              st_miss
);
    logic              ld_act, full_hit, partial, st_stall;
    logic              buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic [BE_W-1:0]   buf_be;

    assign ld_act = ld_req && !st_req;

    sdb_match #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_match (
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_be    (buf_be),
        .ld_act    (ld_act),
        .ld_addr   (ld_addr),
        .ld_be     (ld_be),
        .full_hit  (full_hit),
        .partial   (partial)
    );

    sdb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_req     (st_req),
        .st_addr    (st_addr),
        .st_data    (st_data),
        .st_be      (st_be),
        .ld_act     (ld_act),
        .ld_partial (partial),
        .tc_valid   (tc_valid),
        .tc_hit     (tc_hit),
        .arr_busy   (arr_busy),
        .buf_valid  (buf_valid),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .buf_be     (buf_be),
        .arr_we     (arr_we),
        .st_stall   (st_stall),
        .tc_miss    (st_miss)
    );

    always_comb begin
        arr_addr  = buf_addr;
        arr_wdata = buf_data;
        arr_be    = buf_be;
        fwd_valid = full_hit;
        fwd_data  = full_hit ? buf_data : '0;
        stall     = st_stall || partial;
    end

    AST_FWD_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !stall); // R5
    AST_NO_WRITE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !st_req && !stall) |-> !arr_we); // R11
    AST_NO_WRITE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        st_miss |=> !arr_we); // R4
endmodule

// File: tb/store_delay_buf_test.sv
module store_delay_buf_test;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_req, ld_req, tc_valid, tc_hit, arr_busy;
    logic [AW-1:0] st_addr, ld_addr;
    logic [DW-1:0] st_data;
    logic [BW-1:0] st_be, ld_be;
    logic          arr_we, fwd_valid, stall, st_miss;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata, fwd_data;
    logic [BW-1:0] arr_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    store_delay_buf #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .ld_req(ld_req), .ld_addr(ld_addr), .ld_be(ld_be),
        .tc_valid(tc_valid), .tc_hit(tc_hit), .arr_busy(arr_busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_be(arr_be),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .stall(stall), .st_miss(st_miss)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chkv(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    // Drive at the falling edge; outputs are checked 1 ns later, before the rising edge.
    task automatic idle();
        @(negedge clk);
        st_req = 0; ld_req = 0; tc_valid = 0; tc_hit = 0; arr_busy = 0;
        #1;
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b, input bit busy);
        @(negedge clk);
        st_req = 1; st_addr = a; st_data = d; st_be = b;
        ld_req = 0; tc_valid = 0; tc_hit = 0; arr_busy = busy;
        #1;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [BW-1:0] b, input bit busy);
        @(negedge clk);
        st_req = 0; ld_req = 1; ld_addr = a; ld_be = b;
        tc_valid = 0; tc_hit = 0; arr_busy = busy;
        #1;
    endtask

    task automatic tag(input bit hit, input bit busy);
        @(negedge clk);
        st_req = 0; ld_req = 0; tc_valid = 1; tc_hit = hit; arr_busy = busy;
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        st_req = 0; ld_req = 0; tc_valid = 0; tc_hit = 0; arr_busy = 0;
        st_addr = '0; st_data = '0; st_be = '0; ld_addr = '0; ld_be = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chkv("R1 arr_we", {63'b0, arr_we}, 64'd0);
        chkv("R1 fwd_valid", {63'b0, fwd_valid}, 64'd0);
        chkv("R1 stall", {63'b0, stall}, 64'd0);
        chkv("R1 st_miss", {63'b0, st_miss}, 64'd0);
        rst_n = 1;

        // R2 / R5 / R3: store, forward while pending, hit, drain
        store(32'h100, 64'h1111_2222_3333_4444, 8'hFF, 0);
        chkv("R2 no stall on accept", {63'b0, stall}, 64'd0);
        chkv("R2 no write on accept", {63'b0, arr_we}, 64'd0);
        idle();
        chkv("R2 no write while pending", {63'b0, arr_we}, 64'd0);
        load(32'h100, 8'h0F, 0);
        chkv("R5 fwd pending", {63'b0, fwd_valid}, 64'd1);
        chkv("R5 fwd data", fwd_data, 64'h1111_2222_3333_4444);
        tag(1, 0);
        chkv("R2 no write in hit cycle", {63'b0, arr_we}, 64'd0);
        idle();
        chkv("R3 write after hit", {63'b0, arr_we}, 64'd1);
        chkv("R3 write addr", {32'b0, arr_addr}, 64'h100);
        chkv("R3 write data", arr_wdata, 64'h1111_2222_3333_4444);
        chkv("R3 write be", {56'b0, arr_be}, 64'hFF);
        idle();
        chkv("R3 empty after write", {63'b0, arr_we}, 64'd0);
        load(32'h100, 8'hFF, 0);
        chkv("R3 no fwd after drain", {63'b0, fwd_valid}, 64'd0);

        // R4: miss drops
        store(32'h200, 64'hAAAA, 8'hFF, 0);
        tag(0, 0);
        chkv("R4 miss pulse", {63'b0, st_miss}, 64'd1);
        idle();
        chkv("R4 no write", {63'b0, arr_we}, 64'd0);
        chkv("R4 miss one cycle", {63'b0, st_miss}, 64'd0);
        load(32'h200, 8'hFF, 0);
        chkv("R4 no fwd", {63'b0, fwd_valid}, 64'd0);

        // R10: tag result with nothing pending
        tag(1, 0);
        chkv("R10 no miss", {63'b0, st_miss}, 64'd0);
        idle();
        chkv("R10 no write", {63'b0, arr_we}, 64'd0);
        tag(0, 0);
        chkv("R10 no miss on miss", {63'b0, st_miss}, 64'd0);

        // Confirmed entry held by arr_busy; sweep all load byte masks
        store(32'h300, 64'hDEAD_BEEF_0123_4567, 8'h0F, 0);
        tag(1, 0);
        for (int m = 1; m < 256; m++) begin
            logic [BW-1:0] lb;
            bit exp_f, exp_s;
            lb = m[BW-1:0];
            exp_f = ((lb & ~8'h0F) == 8'h00);
            exp_s = ((lb & 8'h0F) != 8'h00) && !exp_f;
            load(32'h300, lb, 1);
            chkv("R5 sweep fwd", {63'b0, fwd_valid}, {63'b0, exp_f});
            chkv("R6 sweep stall", {63'b0, stall}, {63'b0, exp_s});
            chkv("R5 sweep data", fwd_data, exp_f ? 64'hDEAD_BEEF_0123_4567 : 64'd0);
            chkv("R3 busy blocks write", {63'b0, arr_we}, 64'd0);
        end
        load(32'h304, 8'h0F, 1);
        chkv("R7 other addr fwd", {63'b0, fwd_valid}, 64'd0);
        chkv("R7 other addr stall", {63'b0, stall}, 64'd0);
        load(32'h300, 8'hF0, 1);
        chkv("R7 disjoint fwd", {63'b0, fwd_valid}, 64'd0);
        chkv("R7 disjoint stall", {63'b0, stall}, 64'd0);
        // R11: unstalled load blocks the write
        load(32'h300, 8'h03, 0);
        chkv("R11 no write under load", {63'b0, arr_we}, 64'd0);
        chkv("R11 fwd", {63'b0, fwd_valid}, 64'd1);
        // R6: partial load, confirmed, not busy -> drains same cycle
        load(32'h300, 8'h18, 0);
        chkv("R6 partial stall", {63'b0, stall}, 64'd1);
        chkv("R6 drain in stall", {63'b0, arr_we}, 64'd1);
        chkv("R6 drain addr", {32'b0, arr_addr}, 64'h300);
        load(32'h300, 8'h18, 0);
        chkv("R6 released", {63'b0, stall}, 64'd0);
        chkv("R6 no fwd", {63'b0, fwd_valid}, 64'd0);

        // R8 / R9: back-to-back stores
        store(32'h400, 64'h4040, 8'hFF, 0);
        tag(1, 0);
        store(32'h500, 64'h5050, 8'hFF, 0);
        chkv("R8 no stall", {63'b0, stall}, 64'd0);
        chkv("R8 old written", {63'b0, arr_we}, 64'd1);
        chkv("R8 old addr", {32'b0, arr_addr}, 64'h400);
        load(32'h500, 8'hFF, 1);
        chkv("R8 new pending fwd", fwd_data, 64'h5050);
        store(32'h600, 64'h6060, 8'hFF, 0);
        chkv("R9 stall on pending", {63'b0, stall}, 64'd1);
        tag(1, 0);
        store(32'h600, 64'h6060, 8'hFF, 1);
        chkv("R9 stall on busy", {63'b0, stall}, 64'd1);
        chkv("R9 no write busy", {63'b0, arr_we}, 64'd0);
        store(32'h600, 64'h6060, 8'hFF, 0);
        chkv("R9 accepted after", {63'b0, stall}, 64'd0);
        chkv("R9 held entry written", {32'b0, arr_addr}, 64'h500);
        chkv("R9 held data", arr_wdata, 64'h5050);
        load(32'h600, 8'hFF, 1);
        chkv("R9 newest pending", fwd_data, 64'h6060);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule